// File: doc/BRIEF.md
# Cartridge Bank Mapper with Indirect Register Port

This block sits between an 8-bit console's buses and the cartridge ROMs. On the CPU side it watches writes. An address mask picks out one select port and three aliased data ports. The select port chooses one of eight 3-bit internal registers, and a data write then fills the chosen register. Those registers set which 32KiB program bank appears at CPU $8000-$FFFF. They also set which 1KiB pattern bank sits behind each of the four slots in PPU $0000-$0FFF. The PPU $1000-$1FFF window always shows the final 4KiB of pattern ROM.

The 5-bit pattern bank of each lower slot is put together from several registers. Slot 0 reaches only banks 0-7. Slots 1 and 2 can also set bank bit 4. Slot 3 can set both bit 3 and bit 4, so it can reach every bank. A mode register sets the nametable page select line (the A10 input of the console's nametable RAM). The same register holds a "simple" flag. That flag forces vertical arrangement and makes all four lower slots follow register 0.

Both translations are combinational from the bus addresses. A register update takes effect on the clock edge that ends a CPU write cycle. The write strobe is a single-cycle qualifier. The bus has no back-pressure, so the port has no ready signal.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the select index and all eight registers are 0. As a result, PRG bank 0 is mapped, every lower CHR slot uses bank 0, and the nametable select follows PPU address bit 11.
- R2: A write (cpu_wr high at a rising clock edge) to an address whose value ANDed with 16'hC101 equals 16'h4100 loads cpu_data[2:0] into the select index.
- R3: A write whose masked address is 16'h4000, 16'h4001 or 16'h4101 stores cpu_data[2:0] into the register named by the select index. A write to any other address, or any cycle with cpu_wr low, leaves the index and all registers unchanged.
- R4: prg_addr equals {register 5 bits [PRG_AW-16:0], cpu_addr[14:0]}. With the default 128KiB this is {reg5[1:0], cpu_addr[14:0]}.
- R5: With simple mode off and ppu_addr[12]=0, chr_addr = {bank, ppu_addr[9:0]}. The slot is ppu_addr[11:10], and the bank for each slot is: slot 0 {2'b00, reg0}; slot 1 {reg4[0], 1'b0, reg1}; slot 2 {reg4[1], 1'b0, reg2}; slot 3 {reg4[2], reg6[0], reg3}.
- R6: With ppu_addr[12]=1, the bank is 28 + ppu_addr[11:10] in every mode.
- R7: When register 7 bit 0 is 1 (simple mode), the bank for every lower slot is {2'b00, reg0}, and ciram_a10 equals ppu_addr[10].
- R8: With simple mode off, register 7 bits [2:1] choose the nametable arrangement. 0 gives ciram_a10 = ppu_addr[11]. 1 gives ppu_addr[10]. 2 gives ppu_addr[11] OR ppu_addr[10]. 3 gives a constant 0.
- R9: Data bits [7:3] are ignored on every port. Register 6 keeps only bit 0, so the value written to it changes nothing except slot 3 bank bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write qualifier, one clock per CPU write |
| ppu_addr | input | 14 | PPU address bus |
| prg_addr | output | PRG_AW (17) | Program ROM address |
| chr_addr | output | 15 | Pattern ROM address |
| ciram_a10 | output | 1 | Nametable page select |

## Verification
On every cycle the assertions check the following. Register contents and the index hold while no write occurs. A select or data write lands in the right place with the upper data bits stripped, and register 6 never holds more than one bit. The upper pattern window is fixed. Slot 0 never leaves banks 0-7. Simple mode and single-screen mode drive the nametable select correctly. Only the bench's scenarios can show the full address composition for each slot and the four arrangement encodings. They also cover the aliasing of the three data ports under random don't-care address bits, and the value written to the mode register by the one known program, which must give vertical arrangement.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int IDX_W       = 3;
  localparam int NREGS       = 1 << IDX_W;
  localparam int FIELD_W     = 3;
  localparam int NSLOTS      = 4;
  localparam int SLOT_OFS_W  = 10;
  localparam int SLOT_BANK_W = 5;
  localparam int CHR_AW      = SLOT_BANK_W + SLOT_OFS_W;

  localparam logic [15:0] DEC_MASK  = 16'hC101;
  localparam logic [15:0] SEL_MATCH = 16'h4100;
  localparam logic [15:0] DAT_M0    = 16'h4000;
  localparam logic [15:0] DAT_M1    = 16'h4001;
  localparam logic [15:0] DAT_M2    = 16'h4101;

  localparam int R_HI4  = 4;
  localparam int R_PRG  = 5;
  localparam int R_HI3  = 6;
  localparam int R_MODE = 7;

  typedef logic [FIELD_W-1:0] field_t;
  typedef field_t [NREGS-1:0] regbank_t;

  typedef enum logic [1:0] {MIR_HORZ, MIR_VERT, MIR_SPLIT1, MIR_ONE_A} mirror_e;
  typedef enum logic [1:0] {PORT_NONE, PORT_SEL, PORT_DATA} port_e;

  function automatic port_e decode_port(input logic [15:0] a);
    logic [15:0] m;
    m = a & DEC_MASK;
    if (m == SEL_MATCH) return PORT_SEL;
    if (m == DAT_M0 || m == DAT_M1 || m == DAT_M2) return PORT_DATA;
    return PORT_NONE;
  endfunction
endpackage

// File: rtl/cart_map_regs.sv
module cart_map_regs
  import cart_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  output regbank_t    regs
);
  port_e            hit;
  logic [IDX_W-1:0] idx;
  logic             unused_hi;

  assign hit       = decode_port(cpu_addr);
  assign unused_hi = ^cpu_data[7:FIELD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (cpu_wr && hit == PORT_SEL) begin
      idx <= cpu_data[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (cpu_wr && hit == PORT_DATA) begin
      for (int i = 0; i < NREGS; i++) begin
        if (idx == IDX_W'(i)) begin
          regs[i] <= (i == R_HI3) ? {{(FIELD_W-1){1'b0}}, cpu_data[0]}
                                  : cpu_data[FIELD_W-1:0];
        end
      end
    end
  end

  // R2: select port loads the index from the low data bits
  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && hit == PORT_SEL) |=> idx == $past(cpu_data[IDX_W-1:0]));

  // R3: nothing moves without a write strobe
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(regs) && $stable(idx)));

  // R3: unmatched addresses leave state alone
  a_r3_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && hit == PORT_NONE) |=> ($stable(regs) && $stable(idx)));

  // R9: register 6 never carries more than its single bit
  a_r9_reg6_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    regs[R_HI3][FIELD_W-1:1] == '0);

  for (genvar g = 0; g < NREGS; g++) begin : g_chk
    localparam field_t KEEP = (g == R_HI3) ? field_t'(1) : '1;
    // R3, R9: data write lands in the selected register, upper bits dropped
    a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && hit == PORT_DATA && idx == IDX_W'(g))
        |=> regs[g] == ($past(cpu_data[FIELD_W-1:0]) & KEEP));
  end
endmodule

// File: rtl/cart_map_chr.sv
module cart_map_chr
  import cart_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       ppu_addr,
  input  regbank_t          regs,
  output logic [CHR_AW-1:0] chr_addr
);
  localparam int SLOT_W = $clog2(NSLOTS);

  logic [SLOT_BANK_W-1:0] lo_bank [NSLOTS];
  logic [SLOT_BANK_W-1:0] bank;
  logic [SLOT_W-1:0]      slot;
  logic                   simple;
  logic                   upper;
  logic                   unused_chr;

  assign slot   = ppu_addr[SLOT_OFS_W +: SLOT_W];
  assign upper  = ppu_addr[SLOT_OFS_W + SLOT_W];
  assign simple = regs[R_MODE][0];
  assign unused_chr = ^{regs[R_PRG], regs[R_MODE][FIELD_W-1:1],
                        regs[R_HI3][FIELD_W-1:1], ppu_addr[13]};

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    if (s == 0) begin : g_s0
      assign lo_bank[s] = {2'b00, regs[0]};
    end else if (s == NSLOTS - 1) begin : g_slast
      assign lo_bank[s] = {regs[R_HI4][s-1], regs[R_HI3][0], regs[s]};
    end else begin : g_smid
      assign lo_bank[s] = {regs[R_HI4][s-1], 1'b0, regs[s]};
    end
  end

  always_comb begin
    if (upper)       bank = {{(SLOT_BANK_W-SLOT_W){1'b1}}, slot};
    else if (simple) bank = {2'b00, regs[0]};
    else             bank = lo_bank[slot];
  end

  assign chr_addr = {bank, ppu_addr[SLOT_OFS_W-1:0]};

  // R6: upper pattern window is pinned to the final 4KiB
  a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    upper |-> (chr_addr[CHR_AW-1:SLOT_OFS_W+SLOT_W] == '1 &&
               chr_addr[SLOT_OFS_W+SLOT_W-1:0] == ppu_addr[SLOT_OFS_W+SLOT_W-1:0]));

  // R5: slot 0 never leaves banks 0-7
  a_r5_slot0_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!upper && slot == '0) |-> chr_addr[CHR_AW-1:CHR_AW-2] == 2'b00);

  // R7: simple mode routes register 0 to every lower slot
  a_r7_simple_chr: assert property (@(posedge clk) disable iff (!rst_n)
    (simple && !upper) |-> chr_addr[CHR_AW-1:SLOT_OFS_W] == {2'b00, regs[0]});
endmodule

// File: rtl/cart_map_mirror.sv
module cart_map_mirror
  import cart_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] ppu_addr,
  input  field_t      mode,
  output logic        ciram_a10
);
  mirror_e arr;
  logic    simple;
  logic    unused_mir;

  assign arr        = mirror_e'(mode[2:1]);
  assign simple     = mode[0];
  assign unused_mir = ^{ppu_addr[13:12], ppu_addr[9:0]};

  always_comb begin
    if (simple) begin
      ciram_a10 = ppu_addr[10];
    end else begin
      unique case (arr)
        MIR_HORZ:   ciram_a10 = ppu_addr[11];
        MIR_VERT:   ciram_a10 = ppu_addr[10];
        MIR_SPLIT1: ciram_a10 = ppu_addr[11] | ppu_addr[10];
        default:    ciram_a10 = 1'b0;
      endcase
    end
  end

  // R7: simple mode always gives vertical arrangement
  a_r7_simple_vert: assert property (@(posedge clk) disable iff (!rst_n)
    simple |-> ciram_a10 == ppu_addr[10]);

  // R8: single-screen pins the select low
  a_r8_one_screen: assert property (@(posedge clk) disable iff (!rst_n)
    (!simple && arr == MIR_ONE_A) |-> !ciram_a10);

  // R8: split arrangement puts only the first quarter on page 0
  a_r8_split_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!simple && arr == MIR_SPLIT1) |-> ciram_a10 == (ppu_addr[11:10] != 2'b00));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int PRG_AW = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_wr,
  input  logic [13:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic [14:0]       chr_addr,
  output logic              ciram_a10
);
  localparam int PRG_BANK_W = PRG_AW - 15;

  regbank_t regs;
  logic     unused_top;

  assign unused_top = ^{regs[R_PRG], cpu_addr[15]};

  cart_map_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .regs     (regs)
  );

  cart_map_chr u_chr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ppu_addr (ppu_addr),
    .regs     (regs),
    .chr_addr (chr_addr)
  );

  cart_map_mirror u_mir (
    .clk       (clk),
    .rst_n     (rst_n),
    .ppu_addr  (ppu_addr),
    .mode      (regs[R_MODE]),
    .ciram_a10 (ciram_a10)
  );

  assign prg_addr = {regs[R_PRG][PRG_BANK_W-1:0], cpu_addr[14:0]};

  // R4: the program bank only changes on a write cycle
  a_r4_prg_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(prg_addr[PRG_AW-1:15]));
endmodule

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [16:0] prg_addr;
  logic [14:0] chr_addr;
  logic        ciram_a10;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [2:0] m_reg [8];
  logic [2:0] m_idx;

  always #2.5 clk = ~clk;

  cart_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .ciram_a10(ciram_a10)
  );

  task automatic report_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      report_end();
    end
  end

  function automatic logic [14:0] exp_chr(input logic [13:0] pa);
    logic [4:0] b;
    logic [1:0] s;
    s = pa[11:10];
    if (pa[12]) b = {3'b111, s};
    else if (m_reg[7][0]) b = {2'b00, m_reg[0]};
    else begin
      case (s)
        2'd0: b = {2'b00, m_reg[0]};
        2'd1: b = {m_reg[4][0], 1'b0, m_reg[1]};
        2'd2: b = {m_reg[4][1], 1'b0, m_reg[2]};
        default: b = {m_reg[4][2], m_reg[6][0], m_reg[3]};
      endcase
    end
    return {b, pa[9:0]};
  endfunction

  function automatic logic exp_a10(input logic [13:0] pa);
    if (m_reg[7][0]) return pa[10];
    case (m_reg[7][2:1])
      2'd0: return pa[11];
      2'd1: return pa[10];
      2'd2: return pa[11] | pa[10];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [16:0] exp_prg(input logic [15:0] ca);
    return {m_reg[5][1:0], ca[14:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] m;
    m = a & 16'hC101;
    if (m == 16'h4100) m_idx = d[2:0];
    else if (m == 16'h4000 || m == 16'h4001 || m == 16'h4101)
      m_reg[m_idx] = (m_idx == 3'd6) ? {2'b00, d[0]} : d[2:0];
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic strobe);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = strobe;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (strobe) model_write(a, d);
  endtask

  task automatic set_reg(input logic [2:0] r, input logic [7:0] d);
    cpu_write(16'h4100, {5'b0, r}, 1'b1);
    cpu_write(16'h4101, d, 1'b1);
  endtask

  task automatic probe(input string rc, input string rm, input string rp,
                       input logic [13:0] pa, input logic [15:0] ca);
    ppu_addr = pa; cpu_addr = ca;
    #1;
    check(rc, 32'(chr_addr), 32'(exp_chr(pa)));
    check(rm, 32'(ciram_a10), 32'(exp_a10(pa)));
    check(rp, 32'(prg_addr), 32'(exp_prg(ca)));
  endtask

  task automatic probe_auto(input logic [13:0] pa, input logic [15:0] ca);
    string rc, rm;
    rc = pa[12] ? "R6" : (m_reg[7][0] ? "R7" : "R5");
    rm = m_reg[7][0] ? "R7" : "R8";
    probe(rc, rm, "R4", pa, ca);
  endtask

  initial begin
    logic [15:0] bases [4];
    bases[0] = 16'h4100; bases[1] = 16'h4000; bases[2] = 16'h4001; bases[3] = 16'h4101;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_idx = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, expected values fixed by hand
    ppu_addr = 14'h0C55; cpu_addr = 16'hFFFF; #1;
    check("R1", 32'(chr_addr), 32'h0055);
    check("R1", 32'(prg_addr), 32'h07FFF);
    ppu_addr = 14'h2800; #1;
    check("R1", 32'(ciram_a10), 32'h1);

    // R2, R3, R9: select 5 via a mirrored select address, upper data bits dropped
    cpu_write(16'h5FFE, 8'hFD, 1'b1);
    cpu_write(16'h4001, 8'hFE, 1'b1);
    ppu_addr = 14'h0000; cpu_addr = 16'h8123; #1;
    check("R2", 32'(prg_addr), 32'h10123);

    // R3: matching address without strobe, and unmatched address with strobe
    cpu_write(16'h4101, 8'h01, 1'b0);
    cpu_write(16'h8000, 8'h01, 1'b1);
    cpu_write(16'hC100, 8'h01, 1'b1);
    cpu_addr = 16'h8123; #1;
    check("R3", 32'(prg_addr), 32'h10123);

    // R5: each slot built from its own registers
    set_reg(3'd0, 8'h03); set_reg(3'd1, 8'h05); set_reg(3'd2, 8'h06);
    set_reg(3'd3, 8'h07); set_reg(3'd4, 8'h07); set_reg(3'd6, 8'h01);
    for (int s = 0; s < 4; s++) probe("R5", "R8", "R4", 14'(s * 16'h0400 + 16'h0123), 16'hA5A5);
    ppu_addr = 14'h0C00; #1;
    check("R5", 32'(chr_addr), 32'h7C00);
    ppu_addr = 14'h0400; #1;
    check("R5", 32'(chr_addr), 32'h5400);

    // R9: reg 6 keeps only bit 0 (write 6 -> bit 0 clear)
    set_reg(3'd6, 8'h06);
    ppu_addr = 14'h0C00; #1;
    check("R9", 32'(chr_addr), 32'h5C00);

    // R6: fixed upper window
    for (int s = 0; s < 4; s++) probe("R6", "R8", "R4", 14'(16'h1000 + s * 16'h0400 + 16'h03FF), 16'h8000);

    // R8: all four arrangements
    for (int m = 0; m < 4; m++) begin
      set_reg(3'd7, 8'(m * 2));
      for (int q = 0; q < 4; q++) probe("R5", "R8", "R4", 14'(16'h2000 + q * 16'h0400), 16'h8000);
    end
    // R8: value written by the known program gives vertical arrangement
    set_reg(3'd7, 8'h02);
    ppu_addr = 14'h2400; #1; check("R8", 32'(ciram_a10), 32'h1);
    ppu_addr = 14'h2800; #1; check("R8", 32'(ciram_a10), 32'h0);

    // R7: simple mode overrides both arrangement and slot registers
    set_reg(3'd7, 8'h07);
    for (int q = 0; q < 4; q++) probe("R7", "R7", "R4", 14'(16'h2000 + q * 16'h0400), 16'h9000);
    for (int q = 0; q < 4; q++) probe("R7", "R7", "R4", 14'(q * 16'h0400 + 16'h0011), 16'h9000);
    ppu_addr = 14'h0C00; #1;
    check("R7", 32'(chr_addr), 32'h0C00);

    // random phase
    for (int it = 0; it < 600; it++) begin
      logic [15:0] a;
      int k;
      k = $urandom_range(0, 4);
      if (k < 4) a = bases[k] | (16'($urandom) & ~16'hC101);
      else a = 16'($urandom);
      cpu_write(a, 8'($urandom), ($urandom_range(0, 7) != 0));
      probe_auto(14'($urandom), 16'($urandom) | 16'h8000);
    end

    report_end();
  end
endmodule